// File: doc/BRIEF.md
# Multi-format serial audio input receiver

This block turns a serial audio stream (bit clock, frame clock and one data line) into parallel stereo samples. The bit clock and frame clock are treated as plain signals sampled by the block's system clock, so they must already be synchronous to it and slower than it. The block finds the active bit-clock edge and counts bit positions from each frame-clock boundary. It writes every accepted bit straight into its place in a 24-bit word, MSB first, and sends each finished word to the left or right channel.

Four framings share one engine: left-justified, I2S, right-justified with a selectable word length, and a pulse-framed DSP mode. A stereo pair is released when the right word of a frame is complete. The block sees that completion at the boundary that opens the next left half, or the next pulse in DSP mode. Both channel outputs then change together, with a single-cycle valid strobe.

Top module: `aud_rx_top`

## Requirements
- R1: While `rst` is high, and until the first pair is released, `left_out` and `right_out` read zero and `valid_out` is low.
- R2: `fmt_sel` picks the framing: 2'b00 I2S, 2'b01 left-justified, 2'b10 right-justified, 2'b11 DSP pulse mode. The value is held steady while the stream runs.
- R3: Left-justified: the left word is sent while `lrclk_in` is high and the right word while it is low. Data is sampled on the rising bit-clock edge, and the MSB is the bit sampled at the first edge that sees the new frame-clock level.
- R4: I2S: the left word is sent while `lrclk_in` is low. The MSB comes one bit after the first bit that sees the new frame-clock level, and data is sampled on rising edges.
- R5: Right-justified: each channel half is 32 bit clocks long and the word fills its last N bits, so the MSB sits at bit 32-N of the half. `rj_len` 2'b00 or 2'b11 selects N=24, 2'b01 selects N=20 and 2'b10 selects N=16. Data is sampled on rising edges.
- R6: Right-justified: bits in a half before the word starts have no effect on the output.
- R7: DSP mode: data is sampled on the falling bit-clock edge. A half starts with `lrclk_in` high for one or more bits, and the MSB is the first bit with `lrclk_in` low after that. The first pulse after reset carries left, and later pulses alternate right, left, and so on.
- R8: In left-justified, I2S and DSP modes, a word longer than 24 bits is accepted. Only its first 24 bits reach the output.
- R9: A word shorter than 24 bits, in any mode, appears in the upper bits of the output with zeros below it.
- R10: `valid_out` is high for exactly one clock each time a right word completes after a left word. The outputs change only in that cycle, and one pulse is given per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Framing select (R2 encoding) |
| rj_len | input | 2 | Word length for right-justified mode (R5 encoding) |
| bclk_in | input | 1 | Serial bit clock, synchronous to `clk` |
| lrclk_in | input | 1 | Frame clock or frame pulse |
| sdata_in | input | 1 | Serial data, two's complement, MSB first |
| left_out | output | 24 | Last released left sample |
| right_out | output | 24 | Last released right sample |
| valid_out | output | 1 | One-clock strobe when a stereo pair is released |

## Verification
The hardest case is the position at which each framing and word length puts its MSB. That position is set by a bit count that only the frame clock restarts, and by the sampling edge, which reverses in DSP mode. The stimulus sweeps every framing over several word lengths: short, exactly 24, and longer than 24 where the slot allows. Bits outside the word are filled with ones in right-justified mode, so ignored leading bits would corrupt the result if they were taken. Each run ends with one extra half, so that the last right word is released and counted.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int AUD_SAMPLE_W = 24;
    localparam int AUD_SLOT_BITS = 32;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    typedef struct packed {
        logic stb;
        logic dat;
        logic lr;
    } bit_ev_t;

    function automatic int unsigned rj_bits(input logic [1:0] len, input int unsigned full);
        case (len)
            2'b01:   return full - 4;
            2'b10:   return full - 8;
            default: return full;
        endcase
    endfunction

    function automatic logic left_level(input fmt_e f);
        return (f == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge
    import aud_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fall_mode,
    input  logic    bclk_in,
    input  logic    lrclk_in,
    input  logic    sdata_in,
    output bit_ev_t ev
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bclk_in;
    end

    always_comb begin
        ev.stb = fall_mode ? (bclk_q & ~bclk_in) : (~bclk_q & bclk_in);
        ev.dat = sdata_in;
        ev.lr  = lrclk_in;
    end

    // Two strobes can never fall on adjacent clocks: the bit clock must toggle twice.
    p_strobe_spaced_r3: assert property (@(posedge clk) disable iff (rst)
        ev.stb |=> !ev.stb);

endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 6
)(
    input  logic             clk,
    input  logic             rst,
    input  fmt_e             fmt,
    input  bit_ev_t          ev,
    output logic             half_start,
    output logic             data_stb,
    output logic [CNT_W-1:0] data_idx,
    output logic             commit,
    output logic             commit_left
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             lr_prev;
    logic             primed;
    logic             started;
    logic             chan_left;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic             is_dsp;
    logic             new_left;

    always_comb begin
        is_dsp  = (fmt == FMT_DSP);
        cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + CNT_ONE;
        if (is_dsp) begin
            half_start = ev.stb && ev.lr && !lr_prev;
            data_stb   = ev.stb && !ev.lr && started;
            data_idx   = cnt;
            new_left   = started ? !chan_left : 1'b1;
        end else begin
            half_start = ev.stb && primed && (ev.lr != lr_prev);
            data_stb   = ev.stb && (started || half_start);
            data_idx   = half_start ? '0 : cnt;
            new_left   = (ev.lr == left_level(fmt));
        end
        commit      = half_start && started;
        commit_left = chan_left;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_prev   <= 1'b0;
            primed    <= 1'b0;
            started   <= 1'b0;
            chan_left <= 1'b0;
            cnt       <= '0;
        end else if (ev.stb) begin
            lr_prev <= ev.lr;
            primed  <= 1'b1;
            if (half_start) begin
                started   <= 1'b1;
                chan_left <= new_left;
                cnt       <= is_dsp ? '0 : CNT_ONE;
            end else if (!is_dsp || !ev.lr) begin
                cnt <= cnt_inc;
            end
        end
    end

    p_dsp_alternate_r7: assert property (@(posedge clk) disable iff (rst)
        (is_dsp && half_start && started) |=> (chan_left != $past(chan_left)));

    p_idx_saturates_r8: assert property (@(posedge clk) disable iff (rst)
        (ev.stb && !half_start && !is_dsp && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/aud_rx_shift.sv
module aud_rx_shift
    import aud_rx_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32,
    parameter int CNT_W     = 6
)(
    input  logic                clk,
    input  logic                rst,
    input  fmt_e                fmt,
    input  logic [1:0]          rj_len,
    input  logic                half_start,
    input  logic                data_stb,
    input  logic [CNT_W-1:0]    data_idx,
    input  logic                data_bit,
    output logic [SAMPLE_W-1:0] acc
);
    localparam int KW = CNT_W + 2;

    logic [KW-1:0]       offset;
    logic [KW-1:0]       lim;
    logic [KW-1:0]       idx_w;
    logic [KW-1:0]       k;
    logic                accept;
    logic [SAMPLE_W-1:0] acc_nxt;

    always_comb begin
        case (fmt)
            FMT_I2S: begin
                offset = KW'(1);
                lim    = KW'(SAMPLE_W);
            end
            FMT_RJ: begin
                offset = KW'(SLOT_BITS - int'(rj_bits(rj_len, SAMPLE_W)));
                lim    = KW'(rj_bits(rj_len, SAMPLE_W));
            end
            default: begin
                offset = '0;
                lim    = KW'(SAMPLE_W);
            end
        endcase
        idx_w  = {2'b00, data_idx};
        k      = idx_w - offset;
        accept = data_stb && (idx_w >= offset) && (k < lim);
        acc_nxt = half_start ? '0 : acc;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (accept && (k == KW'(SAMPLE_W - 1 - i))) acc_nxt[i] = data_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc_nxt;
    end

    p_rj16_low_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_RJ && rj_len == 2'b10) |-> (acc[SAMPLE_W-17:0] == '0));

    p_rj_lead_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_RJ && data_stb && !half_start && idx_w < offset) |=> $stable(acc));

endmodule

// File: rtl/aud_rx_out.sv
module aud_rx_out #(
    parameter int SAMPLE_W = 24
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  logic                commit_left,
    input  logic [SAMPLE_W-1:0] word,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                valid_out
);
    logic [SAMPLE_W-1:0] left_hold;
    logic                left_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            left_ok   <= 1'b0;
            left_out  <= '0;
            right_out <= '0;
            valid_out <= 1'b0;
        end else begin
            valid_out <= 1'b0;
            if (commit) begin
                if (commit_left) begin
                    left_hold <= word;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    left_out  <= left_hold;
                    right_out <= word;
                    valid_out <= 1'b1;
                    left_ok   <= 1'b0;
                end
            end
        end
    end

    p_valid_single_r10: assert property (@(posedge clk) disable iff (rst)
        valid_out |=> !valid_out);

    p_left_only_on_valid_r10: assert property (@(posedge clk) disable iff (rst)
        (left_out != $past(left_out)) |-> valid_out);

    p_right_only_on_valid_r10: assert property (@(posedge clk) disable iff (rst)
        (right_out != $past(right_out)) |-> valid_out);

endmodule

// File: rtl/aud_rx_top.sv
module aud_rx_top
    import aud_rx_pkg::*;
#(
    parameter int SAMPLE_W  = AUD_SAMPLE_W,
    parameter int SLOT_BITS = AUD_SLOT_BITS
)(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          rj_len,
    input  logic                bclk_in,
    input  logic                lrclk_in,
    input  logic                sdata_in,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                valid_out
);
    localparam int CNT_W = $clog2(2 * SLOT_BITS);

    fmt_e             fmt;
    bit_ev_t          ev;
    logic             half_start;
    logic             data_stb;
    logic [CNT_W-1:0] data_idx;
    logic             commit;
    logic             commit_left;
    logic [SAMPLE_W-1:0] acc;

    assign fmt = fmt_e'(fmt_sel);

    aud_rx_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .fall_mode(fmt == FMT_DSP),
        .bclk_in  (bclk_in),
        .lrclk_in (lrclk_in),
        .sdata_in (sdata_in),
        .ev       (ev)
    );

    aud_rx_frame #(.CNT_W(CNT_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .fmt        (fmt),
        .ev         (ev),
        .half_start (half_start),
        .data_stb   (data_stb),
        .data_idx   (data_idx),
        .commit     (commit),
        .commit_left(commit_left)
    );

    aud_rx_shift #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .fmt       (fmt),
        .rj_len    (rj_len),
        .half_start(half_start),
        .data_stb  (data_stb),
        .data_idx  (data_idx),
        .data_bit  (ev.dat),
        .acc       (acc)
    );

    aud_rx_out #(.SAMPLE_W(SAMPLE_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .commit_left(commit_left),
        .word       (acc),
        .left_out   (left_out),
        .right_out  (right_out),
        .valid_out  (valid_out)
    );

    p_valid_from_commit_r10: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> ($past(commit) && !$past(commit_left)));

endmodule

// File: tb/sim_aud_rx_top.sv
module sim_aud_rx_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam int NFR = 3;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_sel = 2'b00;
    logic [1:0]  rj_len = 2'b00;
    logic        bclk_in = 1'b0;
    logic        lrclk_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic [23:0] left_out, right_out;
    logic        valid_out;

    int checks = 0;
    int fails = 0;
    int vcount = 0;
    int cycles = 0;
    bit dbl = 1'b0;
    bit prev_v = 1'b0;
    bit dsp_mode = 1'b0;
    string cur_req = "R3";
    logic [31:0] seed = 32'h1234_5678;
    logic [23:0] exp_l [0:NFR-1];
    logic [23:0] exp_r [0:NFR-1];

    aud_rx_top u0 (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .rj_len(rj_len),
        .bclk_in(bclk_in), .lrclk_in(lrclk_in), .sdata_in(sdata_in),
        .left_out(left_out), .right_out(right_out), .valid_out(valid_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Pair monitor (R10 together with the per-mode requirement in cur_req)
    always @(negedge clk) begin
        if (!rst) begin
            if (valid_out && prev_v) dbl = 1'b1;
            if (valid_out) begin
                if (vcount < NFR) begin
                    checks++;
                    if (left_out !== exp_l[vcount] || right_out !== exp_r[vcount]) begin
                        fails++;
                        $display("FAIL %s/R10 pair %0d: actual L=%h R=%h expected L=%h R=%h",
                                 cur_req, vcount, left_out, right_out, exp_l[vcount], exp_r[vcount]);
                    end
                end
                vcount++;
            end
        end
        prev_v = valid_out;
    end

    function automatic logic [31:0] next_val(input int w);
        logic [31:0] v;
        seed = seed * 32'd1103515245 + 32'd12345;
        v = seed ^ (seed >> 13);
        if (w < 32) v = v & ((32'd1 << w) - 32'd1);
        return v;
    endfunction

    // R8 (long words keep their first 24 bits) and R9 (short words zero-filled below)
    function automatic logic [23:0] expect_word(input logic [31:0] v, input int w);
        if (w >= 24) return 24'(v >> (w - 24));
        return 24'(v << (24 - w));
    endfunction

    task automatic send_bit(input logic lr, input logic d);
        if (dsp_mode) begin
            bclk_in = 1'b1; lrclk_in = lr; sdata_in = d;
            repeat (HALF) @(negedge clk);
            bclk_in = 1'b0;
            repeat (HALF) @(negedge clk);
        end else begin
            bclk_in = 1'b0; lrclk_in = lr; sdata_in = d;
            repeat (HALF) @(negedge clk);
            bclk_in = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic send_half(input logic [1:0] f, input logic is_left, input int w, input logic [31:0] v);
        for (int i = 0; i < 32; i++) begin
            logic lr, d;
            case (f)
                2'b01: begin lr = is_left;  d = (i < w) ? v[w-1-i] : 1'b0; end
                2'b00: begin lr = !is_left; d = (i >= 1 && i - 1 < w) ? v[w-i] : 1'b0; end
                2'b10: begin lr = is_left;  d = (i < 32 - w) ? 1'b1 : v[w-1-(i-(32-w))]; end
                default: begin lr = (i == 0); d = (i == 0) ? 1'b1 : ((i - 1 < w) ? v[w-i] : 1'b0); end
            endcase
            send_bit(lr, d);
        end
    endtask

    task automatic run_cfg(input logic [1:0] f, input logic [1:0] len, input int w, input string req);
        logic idle_lr;
        cur_req = req;
        rst = 1'b1;
        fmt_sel = f;
        rj_len = len;
        dsp_mode = (f == 2'b11);
        bclk_in = 1'b0; lrclk_in = 1'b0; sdata_in = 1'b0;
        vcount = 0; dbl = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (left_out !== 24'd0 || right_out !== 24'd0 || valid_out !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual L=%h R=%h V=%b expected 0/0/0", left_out, right_out, valid_out);
        end
        rst = 1'b0;
        idle_lr = (f == 2'b00) ? 1'b1 : 1'b0;
        for (int i = 0; i < 4; i++) send_bit(idle_lr, 1'b0);
        for (int j = 0; j < NFR; j++) begin
            logic [31:0] vl, vr;
            vl = next_val(w);
            vr = next_val(w);
            exp_l[j] = expect_word(vl, w);
            exp_r[j] = expect_word(vr, w);
            send_half(f, 1'b1, w, vl);
            send_half(f, 1'b0, w, vr);
        end
        send_half(f, 1'b1, w, 32'd0);
        repeat (8) @(negedge clk);
        checks++;
        if (vcount != NFR || dbl) begin
            fails++;
            $display("FAIL %s/R10 pulse count: actual %0d (double=%0b) expected %0d (double=0)",
                     req, vcount, dbl, NFR);
        end
    endtask

    initial begin
        // R2 encodings: 00 I2S, 01 LJ, 10 RJ, 11 DSP
        run_cfg(2'b01, 2'b00, 24, "R3");
        run_cfg(2'b01, 2'b00, 16, "R9");
        run_cfg(2'b01, 2'b00, 8,  "R9");
        run_cfg(2'b01, 2'b00, 28, "R8");
        run_cfg(2'b00, 2'b00, 24, "R4");
        run_cfg(2'b00, 2'b00, 23, "R9");
        run_cfg(2'b00, 2'b00, 16, "R2");
        run_cfg(2'b00, 2'b00, 30, "R8");
        run_cfg(2'b10, 2'b00, 24, "R5");
        run_cfg(2'b10, 2'b11, 24, "R5");
        run_cfg(2'b10, 2'b01, 20, "R6");
        run_cfg(2'b10, 2'b10, 16, "R6");
        run_cfg(2'b11, 2'b00, 24, "R7");
        run_cfg(2'b11, 2'b00, 12, "R9");
        run_cfg(2'b11, 2'b00, 26, "R8");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule